// File: doc/BRIEF.md
# Power Management Event Detector

This block gathers the external system-management and wake inputs of a platform into one PCI-clock domain. It produces an active-low system management interrupt and a level wake request. Six inputs arrive asynchronously: an external SMI request that fires on its falling edge, a lid switch, a power button, a ring indicator, a battery-low flag and a bus alert line. Each one passes through a two-flop synchroniser. The lid switch and the power button are also debounced over a parameterised number of clocks, 16 ms at the default.

Each detected event sets a sticky status bit. Software clears a status bit by writing 1 to it. The SMI output is asserted while any status bit that has its SMI enable set is high. The wake request follows the same rule with its own enable set, and can be held off while the battery is low. Ring indicate and bus alert create events only when their feature bit is set. Their synchronised levels can always be read on a plain output, so they can serve as general-purpose inputs.

Configuration is written through a single-cycle register port with no handshake. A write takes effect on the clock edge where `reg_we` is high. There is no data stream and no back-pressure, so the block has no valid/ready interface.

Top module: `pm_event_detect`

## Requirements
- R1: The status bits are numbered as follows: 0 external SMI, 1 lid, 2 power button, 3 ring, 4 bus alert. A low pulse on `ext_smi_n` lasting one clock sets status bit 0.
- R2: A falling edge of `ext_smi_n` counts only if the synchronised input has been high for at least `REARM_CLKS` (default 4) consecutive clocks just before the edge. Any other falling edge is ignored.
- R3: A change on `lid_in` or `pwrbtn_n` that lasts fewer than `DEB_CYCLES` clocks produces no event.
- R4: The control register is at address 2. Its bit 0 enables lid events on a debounced low-to-high change, and its bit 1 enables lid events on a debounced high-to-low change. A lid change whose direction is not enabled sets nothing.
- R5: A debounced high-to-low change of `pwrbtn_n` (a press) sets status bit 2. Releasing the button sets nothing.
- R6: Control bit 3 enables ring events and control bit 4 enables bus alert events. Each event is the falling edge of its active-low input. While a feature bit is clear, its input sets no status. `gpi_val[0]` shows the synchronised `ring_n` level and `gpi_val[1]` shows the synchronised `alert_n` level, each two clocks after the pin.
- R7: A status bit stays set until software writes 1 to that bit at address 3. Writing 0 to a bit leaves it unchanged. If a new event and a clear hit the same bit in the same cycle, the bit stays set.
- R8: The SMI enables are at address 0, one bit per status bit. `smi_n` is low exactly while some status bit and its SMI enable are both 1. A source whose enable is clear still sets its status bit but does not drive `smi_n` low.
- R9: The wake enables are at address 1. `wake_req` is high while some status bit and its wake enable are both 1. It is forced low while control bit 2 is set and the synchronised `batlow_n` is low.
- R10: After reset, all enables, control bits and status bits are 0, `smi_n` is 1 and `wake_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_smi_n | input | 1 | External SMI request, asynchronous, falling-edge |
| lid_in | input | 1 | Lid switch, asynchronous, debounced |
| pwrbtn_n | input | 1 | Power button, active low, debounced |
| ring_n | input | 1 | Ring indicate, active low |
| batlow_n | input | 1 | Battery low, active low |
| alert_n | input | 1 | Bus alert, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 SMI enable, 1 wake enable, 2 control, 3 status clear |
| reg_wdata | input | 5 | Write data, one bit per source or control field |
| smi_n | output | 1 | Active-low system management interrupt |
| wake_req | output | 1 | Wake request level |
| status | output | 5 | Sticky event status bits |
| gpi_val | output | 2 | Synchronised ring and alert levels |

## Verification
The assertions assume that every asynchronous pin holds its level across at least one full clock. They also assume that the battery-low pin is held steady for three clock samples before a blocked wake is expected. The bench meets both assumptions by changing pins only on falling clock edges and by holding `batlow_n` for many cycles. Pulses on `ext_smi_n` and lid bounces are deliberately shorter than the re-arm and debounce windows, but never shorter than one clock.

// File: rtl/pme_pkg.sv
package pme_pkg;
  localparam int SRC_N = 5;

  localparam int SRC_EXT  = 0;
  localparam int SRC_LID  = 1;
  localparam int SRC_PWR  = 2;
  localparam int SRC_RING = 3;
  localparam int SRC_ALRT = 4;

  localparam int CTL_LID_RISE = 0;
  localparam int CTL_LID_FALL = 1;
  localparam int CTL_BAT_BLK  = 2;
  localparam int CTL_RING_ON  = 3;
  localparam int CTL_ALRT_ON  = 4;

  typedef enum logic [1:0] {
    ADR_SMI_EN  = 2'd0,
    ADR_WAKE_EN = 2'd1,
    ADR_CTRL    = 2'd2,
    ADR_STAT    = 2'd3
  } pme_addr_e;

  localparam int PIN_N = 6;
  localparam int PIN_EXT  = 0;
  localparam int PIN_LID  = 1;
  localparam int PIN_PWR  = 2;
  localparam int PIN_BAT  = 3;
  localparam int PIN_RING = 4;
  localparam int PIN_ALRT = 5;
  localparam logic [PIN_N-1:0] PIN_IDLE = 6'b111101;
endpackage

// File: rtl/pme_sync.sv
module pme_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pme_debounce.sv
module pme_debounce #(
  parameter int   CYCLES  = 16,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise,
  output logic fall
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic          stable_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_q <= RST_VAL;
      run_q    <= '0;
      rise     <= 1'b0;
      fall     <= 1'b0;
    end else begin
      rise <= 1'b0;
      fall <= 1'b0;
      if (d == stable_q) begin
        run_q <= '0;
      end else if (run_q == LAST) begin
        stable_q <= d;
        run_q    <= '0;
        rise     <= d;
        fall     <= ~d;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pme_fall_rearm.sv
module pme_fall_rearm #(
  parameter int REARM = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s,
  output logic ev
);
  localparam int CW = $clog2(REARM + 1);
  localparam logic [CW-1:0] FULL = CW'(REARM);

  logic [CW-1:0] high_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_q <= '0;
      ev     <= 1'b0;
    end else begin
      ev <= ~s && (high_q >= FULL);
      if (!s)
        high_q <= '0;
      else if (high_q != FULL)
        high_q <= high_q + 1'b1;
    end
  end
endmodule

// File: rtl/pm_event_detect.sv
module pm_event_detect
  import pme_pkg::*;
#(
  parameter int DEB_CYCLES = 533334,
  parameter int REARM_CLKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_smi_n,
  input  logic             lid_in,
  input  logic             pwrbtn_n,
  input  logic             ring_n,
  input  logic             batlow_n,
  input  logic             alert_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [SRC_N-1:0] reg_wdata,
  output logic             smi_n,
  output logic             wake_req,
  output logic [SRC_N-1:0] status,
  output logic [1:0]       gpi_val
);
  localparam int GP_N = 2;

  logic [PIN_N-1:0] raw, sy;
  logic             ev_ext, lid_r, lid_f, pwr_r, pwr_f;
  logic [GP_N-1:0]  gp_now, gp_prev, gp_feat, gp_ev;
  logic [SRC_N-1:0] smi_en_q, wake_en_q, ctrl_q, set_v, clr_v;
  logic             lid_ev, bat_block;

  assign raw[PIN_EXT]  = ext_smi_n;
  assign raw[PIN_LID]  = lid_in;
  assign raw[PIN_PWR]  = pwrbtn_n;
  assign raw[PIN_BAT]  = batlow_n;
  assign raw[PIN_RING] = ring_n;
  assign raw[PIN_ALRT] = alert_n;

  pme_sync #(.W(PIN_N), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(sy)
  );

  pme_fall_rearm #(.REARM(REARM_CLKS)) u_ext (
    .clk(clk), .rst_n(rst_n), .s(sy[PIN_EXT]), .ev(ev_ext)
  );

  pme_debounce #(.CYCLES(DEB_CYCLES), .RST_VAL(1'b0)) u_lid_db (
    .clk(clk), .rst_n(rst_n), .d(sy[PIN_LID]), .rise(lid_r), .fall(lid_f)
  );

  pme_debounce #(.CYCLES(DEB_CYCLES), .RST_VAL(1'b1)) u_pwr_db (
    .clk(clk), .rst_n(rst_n), .d(sy[PIN_PWR]), .rise(pwr_r), .fall(pwr_f)
  );

  assign lid_ev = (lid_r & ctrl_q[CTL_LID_RISE]) | (lid_f & ctrl_q[CTL_LID_FALL]);

  // Active-low general-purpose style inputs: fall edge becomes an event when enabled
  assign gp_now  = {sy[PIN_ALRT], sy[PIN_RING]};
  assign gp_feat = {ctrl_q[CTL_ALRT_ON], ctrl_q[CTL_RING_ON]};
  assign gpi_val = gp_now;

  for (genvar g = 0; g < GP_N; g++) begin : g_gp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gp_prev[g] <= 1'b1;
      else        gp_prev[g] <= gp_now[g];
    end
    assign gp_ev[g] = gp_feat[g] & gp_prev[g] & ~gp_now[g];
  end

  always_comb begin
    set_v           = '0;
    set_v[SRC_EXT]  = ev_ext;
    set_v[SRC_LID]  = lid_ev;
    set_v[SRC_PWR]  = pwr_f & ~pwr_r;
    set_v[SRC_RING] = gp_ev[0];
    set_v[SRC_ALRT] = gp_ev[1];
  end

  assign clr_v = (reg_we && reg_addr == ADR_STAT) ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smi_en_q  <= '0;
      wake_en_q <= '0;
      ctrl_q    <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        ADR_SMI_EN:  smi_en_q  <= reg_wdata;
        ADR_WAKE_EN: wake_en_q <= reg_wdata;
        ADR_CTRL:    ctrl_q    <= reg_wdata;
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_v) | set_v;
  end

  assign bat_block = ctrl_q[CTL_BAT_BLK] & ~sy[PIN_BAT];
  assign smi_n     = ~|(status & smi_en_q);
  assign wake_req  = (|(status & wake_en_q)) & ~bat_block;
endmodule

// File: rtl/pme_checker.sv
module pme_checker
  import pme_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             batlow_n,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic [SRC_N-1:0] reg_wdata,
  input logic [SRC_N-1:0] ctrl_q,
  input logic [SRC_N-1:0] status,
  input logic             smi_n,
  input logic             wake_req
);
  logic [SRC_N-1:0] keep;
  logic [1:0]       bat_low_cnt;

  assign keep = status & ~((reg_we && reg_addr == 2'd3) ? reg_wdata : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             bat_low_cnt <= '0;
    else if (batlow_n)                      bat_low_cnt <= '0;
    else if (bat_low_cnt != 2'd3)           bat_low_cnt <= bat_low_cnt + 1'b1;
  end

  // R10: reset clears status and quiets outputs
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r10_reset_quiet: assert (status == '0 && smi_n && !wake_req)
        else $error("reset state wrong");
    end
  end

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(keep)) == $past(keep)));

  a_r8_smi_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> smi_n);

  a_r6_ring_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[SRC_RING]) |-> $past(ctrl_q[CTL_RING_ON]));

  a_r6_alert_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[SRC_ALRT]) |-> $past(ctrl_q[CTL_ALRT_ON]));

  a_r9_bat_block: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CTL_BAT_BLK] && !batlow_n && bat_low_cnt >= 2'd2) |-> !wake_req);
endmodule

bind pm_event_detect pme_checker u_pme_chk (
  .clk(clk), .rst_n(rst_n), .batlow_n(batlow_n),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .ctrl_q(ctrl_q), .status(status), .smi_n(smi_n), .wake_req(wake_req)
);

// File: tb/tb_pm_event_detect.sv
module tb_pm_event_detect;
  localparam int DEB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_smi_n = 1'b1, lid_in = 1'b0, pwrbtn_n = 1'b1;
  logic ring_n = 1'b1, batlow_n = 1'b1, alert_n = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [4:0] reg_wdata = '0;
  logic smi_n, wake_req;
  logic [4:0] status;
  logic [1:0] gpi_val;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pm_event_detect #(.DEB_CYCLES(DEB), .REARM_CLKS(4)) dut (
    .clk(clk), .rst_n(rst_n), .ext_smi_n(ext_smi_n), .lid_in(lid_in),
    .pwrbtn_n(pwrbtn_n), .ring_n(ring_n), .batlow_n(batlow_n), .alert_n(alert_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .smi_n(smi_n), .wake_req(wake_req), .status(status), .gpi_val(gpi_val)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [4:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    idle(2);
    check("R10 status", status, 0);
    check("R10 smi_n", smi_n, 1);
    check("R10 wake_req", wake_req, 0);
  endtask

  task automatic ext_pulse;
    @(negedge clk); ext_smi_n = 1'b0;
    @(negedge clk); ext_smi_n = 1'b1;
  endtask

  task automatic t_ext;
    wr(2'd0, 5'h1F);
    idle(8);
    ext_pulse();
    idle(6);
    check("R1 status", status, 5'b00001);
    check("R8 smi_n low", smi_n, 0);
    wr(2'd3, 5'b00001);
    idle(1);
    check("R7 cleared", status, 0);
    check("R8 smi_n high", smi_n, 1);
    wr(2'd0, 5'h00);
    idle(8);
    ext_pulse();
    idle(6);
    check("R8 masked status", status, 5'b00001);
    check("R8 masked smi_n", smi_n, 1);
    wr(2'd3, 5'h1F);
    wr(2'd0, 5'h1F);
  endtask

  task automatic t_rearm;
    idle(10);
    @(negedge clk); ext_smi_n = 1'b0;
    @(negedge clk); ext_smi_n = 1'b1;
    @(negedge clk);
    @(negedge clk); ext_smi_n = 1'b0;
    @(negedge clk);
    check("R2 first edge", status[0], 1);
    ext_smi_n = 1'b1;
    reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = 5'b00001;
    @(negedge clk); reg_we = 1'b0;
    idle(8);
    check("R2 early edge dropped", status[0], 0);
    ext_pulse();
    idle(6);
    check("R2 rearmed edge", status[0], 1);
    wr(2'd3, 5'h1F);
  endtask

  task automatic t_lid;
    wr(2'd2, 5'b00001);
    @(negedge clk); lid_in = 1'b1;
    idle(5); lid_in = 1'b0;
    idle(40);
    check("R3 lid bounce", status[1], 0);
    lid_in = 1'b1; idle(40);
    check("R4 lid rise", status[1], 1);
    wr(2'd3, 5'b00010);
    lid_in = 1'b0; idle(40);
    check("R4 lid fall not enabled", status[1], 0);
    wr(2'd2, 5'b00010);
    lid_in = 1'b1; idle(40);
    check("R4 lid rise not enabled", status[1], 0);
    lid_in = 1'b0; idle(40);
    check("R4 lid fall", status[1], 1);
    wr(2'd3, 5'h1F);
    wr(2'd2, 5'b00000);
  endtask

  task automatic t_pwr;
    @(negedge clk); pwrbtn_n = 1'b0;
    idle(6); pwrbtn_n = 1'b1;
    idle(40);
    check("R3 button glitch", status[2], 0);
    pwrbtn_n = 1'b0; idle(40);
    check("R5 press", status[2], 1);
    wr(2'd3, 5'b00100);
    pwrbtn_n = 1'b1; idle(40);
    check("R5 release", status[2], 0);
  endtask

  task automatic t_gpi;
    @(negedge clk); ring_n = 1'b0; alert_n = 1'b0;
    idle(4);
    check("R6 gpi level low", gpi_val, 2'b00);
    check("R6 disabled no status", status, 0);
    check("R6 disabled smi_n", smi_n, 1);
    ring_n = 1'b1; alert_n = 1'b1;
    idle(4);
    check("R6 gpi level high", gpi_val, 2'b11);
    wr(2'd2, 5'b11000);
    @(negedge clk); ring_n = 1'b0;
    idle(5);
    check("R6 ring event", status, 5'b01000);
    check("R6 ring smi", smi_n, 0);
    alert_n = 1'b0;
    idle(5);
    check("R6 alert event", status, 5'b11000);
    ring_n = 1'b1; alert_n = 1'b1;
    wr(2'd3, 5'b01000);
    idle(1);
    check("R7 partial clear", status, 5'b10000);
    wr(2'd3, 5'b00000);
    idle(1);
    check("R7 zero write keeps", status, 5'b10000);
    wr(2'd3, 5'h1F);
    wr(2'd2, 5'b00000);
  endtask

  task automatic t_bat;
    wr(2'd1, 5'b00100);
    wr(2'd2, 5'b00100);
    @(negedge clk); batlow_n = 1'b0;
    idle(4);
    pwrbtn_n = 1'b0; idle(40);
    check("R9 status set", status[2], 1);
    check("R9 blocked", wake_req, 0);
    batlow_n = 1'b1; idle(4);
    check("R9 unblocked", wake_req, 1);
    batlow_n = 1'b0; idle(4);
    check("R9 reblocked", wake_req, 0);
    wr(2'd2, 5'b00000);
    idle(1);
    check("R9 block off", wake_req, 1);
    pwrbtn_n = 1'b1; batlow_n = 1'b1; idle(40);
    wr(2'd3, 5'h1F);
    idle(1);
    check("R9 wake drops", wake_req, 0);
  endtask

  initial begin
    fork
      begin
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_ext();
        t_rearm();
        t_lid();
        t_pwr();
        t_gpi();
        t_bat();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule